// File: doc/BRIEF.md
# SD Data-Transfer Activity Tracker

This block follows the data phase of an SD host controller and reports whether a read or a write transfer is currently moving data. It receives one-cycle event strobes from the command path (command end bit seen, with its direction and programmed block count) and from the data path (a read block handed to the system side, a write block's CRC status returned, a block still being received). From these strobes it keeps two status flags, read-active and write-active. It also raises one-cycle interrupt pulses when a transfer finishes normally, and when a write halts at a block gap.

Software may ask for a halt at the next block gap and later issue a continue request. A halted transfer is held in a paused state with its remaining block count kept, and it resumes on the continue request. The block also reports a vector of clock-gated-off status bits. Each bit follows an automatic-gating request, but only while no transfer is running.

The controller moves through five named states. `ST_IDLE` has no transfer open. `ST_RD_RUN` and `ST_WR_RUN` each have a transfer moving data. `ST_RD_PAUSE` and `ST_WR_PAUSE` each hold a transfer halted at a block gap. The transitions are:
- start-read and start-write: `ST_IDLE` to a run state on a command end bit.
- finish: a run state to `ST_IDLE` on the last block.
- gap-halt: a run state to its pause state.
- resume: a pause state back to its run state on a continue request.

Top module: `sd_xfer_status`

## Requirements
- R1: `rd_active_o` rises one cycle after `cmd_end_i` with `cmd_is_wr_i`=0 in `ST_IDLE`. It also rises one cycle after `cont_req_i` in `ST_RD_PAUSE`.
- R2: In `ST_RD_RUN`, a `rd_blk_done_i` with a remaining count of 1 or less clears `rd_active_o`. In the same cycle, `xfer_done_o` pulses.
- R3: In `ST_RD_RUN`, a `rd_blk_done_i` that finds a gap request pending (or arriving in that cycle) with `rd_inflight_i`=0 pauses the read. `rd_active_o` falls, and neither `xfer_done_o` nor `gap_evt_o` pulses. With `rd_inflight_i`=1 the read keeps running and the request stays pending.
- R4: `wr_active_o` rises one cycle after `cmd_end_i` with `cmd_is_wr_i`=1 in `ST_IDLE`. It also rises one cycle after `cont_req_i` in `ST_WR_PAUSE`.
- R5: In `ST_WR_RUN`, a `wr_crc_stat_i` with a remaining count of 1 or less clears `wr_active_o`. In the same cycle, `xfer_done_o` pulses.
- R6: In `ST_WR_RUN`, a `wr_crc_stat_i` that finds a gap request pending (or arriving in that cycle) pauses the write. `wr_active_o` falls and `gap_evt_o` pulses in the same cycle.
- R7: If the final block coincides with a gap request, the transfer finishes. `xfer_done_o` pulses, `gap_evt_o` stays 0, and the state is `ST_IDLE`.
- R8: `gated_o` is 0 after reset. One cycle after a clock edge, it equals `gate_req_i` if that edge leaves the controller in `ST_IDLE` or a pause state, and 0 otherwise. `gated_o` is never nonzero while a flag is set.
- R9: `cmd_end_i` is ignored in every state except `ST_IDLE`, so the block count is not reloaded. `cont_req_i` is ignored except in a pause state.
- R10: The block counter loads `blk_cnt_i` on an accepted command end bit. It counts down once per completed block in a run state. A programmed count of 0 is treated as a single block.
- R11: A synchronous active-high `rst` returns the controller to `ST_IDLE`. It clears both flags, both pulses, `gated_o`, the counter and any pending gap request.
- R12: `rd_active_o` and `wr_active_o` are never both 1. `xfer_done_o` and `gap_evt_o` each last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_end_i | input | 1 | End bit of a data command seen |
| cmd_is_wr_i | input | 1 | Direction of that command, 1 = write |
| blk_cnt_i | input | CNT_W | Programmed block count, sampled with `cmd_end_i` |
| rd_blk_done_i | input | 1 | One read block handed to the system side |
| rd_inflight_i | input | 1 | A further read block is still being received |
| wr_crc_stat_i | input | 1 | CRC status of one written block returned |
| cont_req_i | input | 1 | Continue request for a paused transfer |
| gap_req_i | input | 1 | Stop-at-block-gap request |
| gate_req_i | input | NGATE | Automatic clock-gating requests |
| rd_active_o | output | 1 | Read transfer active |
| wr_active_o | output | 1 | Write transfer active |
| xfer_done_o | output | 1 | Transfer-complete interrupt pulse |
| gap_evt_o | output | 1 | Block-gap-event interrupt pulse (write) |
| gated_o | output | NGATE | Clock-gated-off status bits |

## Verification
Every result of this block comes from a register that captures at the clock edge where the strobe is sampled. The flags, both interrupt pulses and the gated-off bits are therefore due exactly one cycle after their stimulus, with no further pipeline. The bench drives each stimulus on the falling edge and reads every output on the following falling edge, one full edge after sampling. It then clears the strobes, so each row of the vector table is one cycle. Pulse width is checked by the row after the pulse, where the pulse output must read 0 again.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_RUN   = 3'd1,
        ST_RD_PAUSE = 3'd2,
        ST_WR_RUN   = 3'd3,
        ST_WR_PAUSE = 3'd4
    } xfer_state_t;
endpackage

// File: rtl/sdx_blk_counter.sv
module sdx_blk_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // a count of zero counts as a single block
    assign last_o = (cnt_q <= ONE);

    // R10
    cnt_reload_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/sdx_xfer_fsm.sv
module sdx_xfer_fsm
    import sdx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_end_i,
    input  logic cmd_is_wr_i,
    input  logic rd_blk_done_i,
    input  logic rd_inflight_i,
    input  logic wr_crc_stat_i,
    input  logic cont_req_i,
    input  logic gap_req_i,
    input  logic last_blk_i,
    output logic cnt_load_o,
    output logic cnt_dec_o,
    output logic quiet_nxt_o,
    output logic rd_active_o,
    output logic wr_active_o,
    output logic xfer_done_o,
    output logic gap_evt_o
);
    xfer_state_t state_q, state_d;
    logic        gap_pend_q;
    logic        stop_now;
    logic        done_d, gevt_d;

    assign stop_now = gap_pend_q | gap_req_i;

    // next state and the pulses that go with each transition
    always_comb begin
        state_d    = state_q;
        done_d     = 1'b0;
        gevt_d     = 1'b0;
        cnt_load_o = 1'b0;
        cnt_dec_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_end_i) begin
                    cnt_load_o = 1'b1;
                    state_d    = cmd_is_wr_i ? ST_WR_RUN : ST_RD_RUN;
                end
            end
            ST_RD_RUN: begin
                if (rd_blk_done_i) begin
                    cnt_dec_o = 1'b1;
                    if (last_blk_i) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else if (stop_now && !rd_inflight_i) begin
                        state_d = ST_RD_PAUSE;
                    end
                end
            end
            ST_RD_PAUSE: begin
                if (cont_req_i) state_d = ST_RD_RUN;
            end
            ST_WR_RUN: begin
                if (wr_crc_stat_i) begin
                    cnt_dec_o = 1'b1;
                    if (last_blk_i) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else if (stop_now) begin
                        state_d = ST_WR_PAUSE;
                        gevt_d  = 1'b1;
                    end
                end
            end
            ST_WR_PAUSE: begin
                if (cont_req_i) state_d = ST_WR_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // pending gap request, dropped once a transfer halts or ends
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_pend_q <= 1'b0;
        end else if ((state_d != ST_RD_RUN) && (state_d != ST_WR_RUN)) begin
            gap_pend_q <= 1'b0;
        end else if (gap_req_i && ((state_q == ST_RD_RUN) || (state_q == ST_WR_RUN))) begin
            gap_pend_q <= 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_done_o <= 1'b0;
            gap_evt_o   <= 1'b0;
        end else begin
            xfer_done_o <= done_d;
            gap_evt_o   <= gevt_d;
        end
    end

    assign rd_active_o = (state_q == ST_RD_RUN);
    assign wr_active_o = (state_q == ST_WR_RUN);
    assign quiet_nxt_o = (state_d != ST_RD_RUN) && (state_d != ST_WR_RUN);

    // R1
    rd_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_active_o) |-> $past(cmd_end_i || cont_req_i));
    // R4
    wr_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_active_o) |-> $past(cmd_end_i || cont_req_i));
    // R6
    gap_evt_write_chk: assert property (@(posedge clk) disable iff (rst)
        gap_evt_o |-> ($fell(wr_active_o) && $past(wr_crc_stat_i)));
    // R2
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done_o |-> ($past(rd_active_o || wr_active_o) && !rd_active_o && !wr_active_o));
    // R12
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done_o |=> !xfer_done_o);
    // R12
    gevt_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        gap_evt_o |=> !gap_evt_o);
    // R7
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(xfer_done_o && gap_evt_o));
endmodule

// File: rtl/sdx_gate_status.sv
module sdx_gate_status #(
    parameter int NGATE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             quiet_i,
    input  logic [NGATE-1:0] gate_req_i,
    output logic [NGATE-1:0] gated_o
);
    for (genvar g = 0; g < NGATE; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) gated_o[g] <= 1'b0;
            else     gated_o[g] <= quiet_i & gate_req_i[g];
        end
    end
endmodule

// File: rtl/sd_xfer_status.sv
module sd_xfer_status #(
    parameter int CNT_W = 16,
    parameter int NGATE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_end_i,
    input  logic             cmd_is_wr_i,
    input  logic [CNT_W-1:0] blk_cnt_i,
    input  logic             rd_blk_done_i,
    input  logic             rd_inflight_i,
    input  logic             wr_crc_stat_i,
    input  logic             cont_req_i,
    input  logic             gap_req_i,
    input  logic [NGATE-1:0] gate_req_i,
    output logic             rd_active_o,
    output logic             wr_active_o,
    output logic             xfer_done_o,
    output logic             gap_evt_o,
    output logic [NGATE-1:0] gated_o
);
    logic cnt_load, cnt_dec, last_blk, quiet_nxt;

    sdx_blk_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cnt_load),
        .load_val_i (blk_cnt_i),
        .dec_i      (cnt_dec),
        .last_o     (last_blk)
    );

    sdx_xfer_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cmd_end_i     (cmd_end_i),
        .cmd_is_wr_i   (cmd_is_wr_i),
        .rd_blk_done_i (rd_blk_done_i),
        .rd_inflight_i (rd_inflight_i),
        .wr_crc_stat_i (wr_crc_stat_i),
        .cont_req_i    (cont_req_i),
        .gap_req_i     (gap_req_i),
        .last_blk_i    (last_blk),
        .cnt_load_o    (cnt_load),
        .cnt_dec_o     (cnt_dec),
        .quiet_nxt_o   (quiet_nxt),
        .rd_active_o   (rd_active_o),
        .wr_active_o   (wr_active_o),
        .xfer_done_o   (xfer_done_o),
        .gap_evt_o     (gap_evt_o)
    );

    sdx_gate_status #(.NGATE(NGATE)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .quiet_i    (quiet_nxt),
        .gate_req_i (gate_req_i),
        .gated_o    (gated_o)
    );

    // R12
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_active_o && wr_active_o));
    // R8
    gated_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (gated_o != '0) |-> (!rd_active_o && !wr_active_o));
    // R9
    cmd_ignored_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_active_o && cmd_end_i && !rd_blk_done_i) |=> rd_active_o);
endmodule

// File: tb/sd_xfer_status_tb_top.sv
module sd_xfer_status_tb_top;
    localparam int CNT_W = 16;
    localparam int NGATE = 4;
    localparam int NROW  = 22;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_end = 0, cmd_wr = 0, bd = 0, infl = 0, crc = 0, cont = 0, gap = 0;
    logic [CNT_W-1:0] cnt = '0;
    logic [NGATE-1:0] gate = '0;
    logic             rd_a, wr_a, done, gevt;
    logic [NGATE-1:0] gated;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sd_xfer_status #(.CNT_W(CNT_W), .NGATE(NGATE)) dut_i (
        .clk(clk), .rst(rst), .cmd_end_i(cmd_end), .cmd_is_wr_i(cmd_wr),
        .blk_cnt_i(cnt), .rd_blk_done_i(bd), .rd_inflight_i(infl),
        .wr_crc_stat_i(crc), .cont_req_i(cont), .gap_req_i(gap),
        .gate_req_i(gate), .rd_active_o(rd_a), .wr_active_o(wr_a),
        .xfer_done_o(done), .gap_evt_o(gevt), .gated_o(gated)
    );

    // {cmd,wr} cnt {bd,crc,cont,gap,infl} gate | exp {rd,wr,done,gevt} gated
    localparam logic [22:0] VEC [NROW] = '{
        {2'b00, 4'd0, 5'b00000, 4'b1010, 4'b0000, 4'b1010}, // R8 idle gating
        {2'b10, 4'd2, 5'b00000, 4'b1111, 4'b1000, 4'b0000}, // R1 R8
        {2'b00, 4'd0, 5'b10000, 4'b0000, 4'b1000, 4'b0000}, // R10
        {2'b00, 4'd0, 5'b10000, 4'b0000, 4'b0010, 4'b0000}, // R2
        {2'b00, 4'd0, 5'b00000, 4'b0000, 4'b0000, 4'b0000}, // R12
        {2'b11, 4'd3, 5'b00000, 4'b0000, 4'b0100, 4'b0000}, // R4
        {2'b10, 4'd1, 5'b00000, 4'b0000, 4'b0100, 4'b0000}, // R9
        {2'b00, 4'd0, 5'b00010, 4'b0000, 4'b0100, 4'b0000}, // R6 pending
        {2'b00, 4'd0, 5'b01000, 4'b0000, 4'b0001, 4'b0000}, // R6
        {2'b00, 4'd0, 5'b00000, 4'b0001, 4'b0000, 4'b0001}, // R8 R12
        {2'b10, 4'd1, 5'b00000, 4'b0000, 4'b0000, 4'b0000}, // R9
        {2'b00, 4'd0, 5'b00100, 4'b0000, 4'b0100, 4'b0000}, // R4
        {2'b00, 4'd0, 5'b01000, 4'b0000, 4'b0100, 4'b0000}, // R10
        {2'b00, 4'd0, 5'b01000, 4'b0000, 4'b0010, 4'b0000}, // R5
        {2'b10, 4'd3, 5'b00000, 4'b0000, 4'b1000, 4'b0000}, // R1
        {2'b00, 4'd0, 5'b10011, 4'b0000, 4'b1000, 4'b0000}, // R3 in flight
        {2'b00, 4'd0, 5'b10000, 4'b0000, 4'b0000, 4'b0000}, // R3
        {2'b00, 4'd0, 5'b00100, 4'b0000, 4'b1000, 4'b0000}, // R1
        {2'b00, 4'd0, 5'b10000, 4'b0000, 4'b0010, 4'b0000}, // R2
        {2'b00, 4'd0, 5'b00100, 4'b0000, 4'b0000, 4'b0000}, // R9
        {2'b11, 4'd1, 5'b00000, 4'b0000, 4'b0100, 4'b0000}, // R4
        {2'b00, 4'd0, 5'b01010, 4'b0000, 4'b0010, 4'b0000}  // R7
    };
    string row_req [NROW] = '{"R8","R1","R10","R2","R12","R4","R9","R6","R6","R8",
                              "R9","R4","R10","R5","R1","R3","R3","R1","R2","R9",
                              "R4","R7"};

    function automatic logic [7:0] observed();
        return {rd_a, wr_a, done, gevt, gated};
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        n_chk++;
        if (observed() !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, observed(), exp);
        end
    endtask

    task automatic step(input logic c, input logic w, input logic [3:0] n,
                        input logic [4:0] ev, input logic [3:0] g);
        cmd_end = c; cmd_wr = w; cnt = CNT_W'(n);
        {bd, crc, cont, gap, infl} = ev;
        gate = g;
        @(posedge clk);
        @(negedge clk);
        cmd_end = 0; cmd_wr = 0; cnt = '0;
        {bd, crc, cont, gap, infl} = 5'b0;
        gate = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", 8'h00);
        rst = 0;

        for (int i = 0; i < NROW; i++) begin
            step(VEC[i][22], VEC[i][21], VEC[i][20:17], VEC[i][16:12], VEC[i][11:8]);
            check(row_req[i], VEC[i][7:0]);
        end

        // R11 reset mid transfer clears flag, counter and pending gap
        step(1'b1, 1'b0, 4'd2, 5'b00000, 4'b0000);
        step(1'b0, 1'b0, 4'd0, 5'b00010, 4'b0000);
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        check("R11", 8'h00);
        rst = 0;
        step(1'b1, 1'b0, 4'd2, 5'b00000, 4'b0000);
        step(1'b0, 1'b0, 4'd0, 5'b10000, 4'b0000);
        check("R11", 8'b1000_0000);
        step(1'b0, 1'b0, 4'd0, 5'b10000, 4'b0000);
        check("R2", 8'b0010_0000);

        // R10 zero count acts as one block
        step(1'b1, 1'b1, 4'd0, 5'b00000, 4'b0000);
        check("R10", 8'b0100_0000);
        step(1'b0, 1'b0, 4'd0, 5'b01000, 4'b0000);
        check("R10", 8'b0010_0000);
        step(1'b0, 1'b0, 4'd0, 5'b00000, 4'b1111);
        check("R12", 8'b0000_1111);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule